// File: doc/BRIEF.md
# PDM Microphone Clock and Sampling Front-End

This block derives a pulse-density-modulation microphone clock from the system clock and samples one shared PDM data line into up to two single-bit streams. The clock is produced by an even divider whose half period is a programmable number of system clocks. A bypass passes the system clock straight to the clock pin, and an output enable decides whether the clock pin toggles at all.

Two microphones can share one data line because each drives it during a different half of the PDM clock. Every channel has a polarity bit that picks the high or the low half. A capture delay, counted in system clocks from the start of that half, sets the exact cycle in which the line is sampled. Each captured bit appears on the channel's output together with a single-cycle strobe, once per PDM period. The block exerts no back-pressure: the consumer must take every strobe in the cycle it appears, and a bit stays on its output only until that channel's next strobe.

Top module: `pdm_frontend`

## Requirements
- R1: During reset and in the first cycle after it, the clock pin, both strobes and both sample bits are 0.
- R2: With divide setting n and no bypass, the divided clock stays n+1 system clocks low, then n+1 high, repeating. The low half comes first, starting at the first enabled clock edge.
- R3: The clock pin is 0 whenever the enable input or the clock output enable input is 0.
- R4: With bypass set, the clock pin follows the system clock. Every enabled channel is sampled at every enabled edge, and polarity and delay are ignored.
- R5: Without bypass, channel c is sampled at the edge where its selected half is in progress and the count of system clocks into that half equals the capture delay. Its strobe is high for exactly the one following cycle, and the sample bit holds the data-line value from that edge.
- R6: Polarity bit c (bit 0 for channel 0, bit 1 for channel 1) set selects the high half of the PDM clock for channel c; clear selects the low half.
- R7: When the two-channel input is 0, only channel 0 is sampled and the channel 1 strobe stays 0.
- R8: A capture delay greater than n is treated as n, the last cycle of the half.
- R9: A change of the divide setting while enabled starts a restart edge. At that edge no channel is sampled and the clock goes low. The pattern of R2 then starts again from the next edge.
- R10: While the enable input is 0, no strobe is produced beyond the one for a sample taken at the last enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Runs the divider and capture |
| cfg_div | input | 4 | Half period minus one, in system clocks |
| cfg_bypass | input | 1 | Pass the system clock to the clock pin, sample every cycle |
| cfg_clk_oe | input | 1 | Lets the generated clock reach the clock pin |
| cfg_capt_dly | input | 4 | Sampling delay into the selected half, in system clocks |
| cfg_pol | input | 2 | Per-channel half select, 1 = high half |
| cfg_two_ch | input | 1 | 1 = sample channels 0 and 1, 0 = channel 0 only |
| pdm_data_i | input | 1 | Shared PDM data line |
| pdm_clk_o | output | 1 | PDM clock pin |
| smp_bit_o | output | 2 | Last captured bit per channel |
| smp_valid_o | output | 2 | One-cycle strobe per channel marking a new bit |

## Verification
The assertions take for granted that bypass, polarity, delay and the channel count change only while the block is disabled, or together with a divide change that forces a restart edge. Only the divide setting is expected to change on the fly. The single-strobe property depends on this, because a bypass switch during a run could join two strobes. The stimulus follows that rule: every run except one begins from a disabled interval, and the one on-the-fly run changes the divide setting in the same cycle as all other settings. The data line is driven from a pseudo-random sequence, so any capture in the wrong cycle shows up as a wrong bit.

// File: rtl/pdm_fe_pkg.sv
package pdm_fe_pkg;
  localparam int FE_CH = 2;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } pdm_phase_e;
endpackage

// File: rtl/pdm_clkdiv.sv
module pdm_clkdiv
  import pdm_fe_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  output logic             phase_hi,
  output logic [DIV_W-1:0] cnt,
  output logic             run
);
  pdm_phase_e       phase_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             restart;

  assign restart  = !enable || (div != div_q);
  assign run      = !restart;
  assign phase_hi = (phase_q == PH_HIGH);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt_q   <= '0;
      phase_q <= PH_LOW;
    end else begin
      div_q <= div;
      if (restart) begin
        cnt_q   <= '0;
        phase_q <= PH_LOW;
      end else if (cnt_q == div) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);

  // R9
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == PH_LOW) && (cnt_q == '0));
endmodule

// File: rtl/pdm_chan_capture.sv
module pdm_chan_capture #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             bypass,
  input  logic             pol_hi,
  input  logic [DIV_W-1:0] dly,
  input  logic             phase_hi,
  input  logic [DIV_W-1:0] cnt,
  input  logic             data_i,
  output logic             bit_o,
  output logic             valid_o
);
  logic hit;
  logic bit_q;
  logic valid_q;

  assign hit = active && (bypass || ((phase_hi == pol_hi) && (cnt == dly)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= hit;
      if (hit) bit_q <= data_i;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !bypass && $past(!bypass)) |=> !valid_q);

  // R5
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(bit_q));
endmodule

// File: rtl/pdm_frontend.sv
module pdm_frontend
  import pdm_fe_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_bypass,
  input  logic             cfg_clk_oe,
  input  logic [DIV_W-1:0] cfg_capt_dly,
  input  logic [FE_CH-1:0] cfg_pol,
  input  logic             cfg_two_ch,
  input  logic             pdm_data_i,
  output logic             pdm_clk_o,
  output logic [FE_CH-1:0] smp_bit_o,
  output logic [FE_CH-1:0] smp_valid_o
);
  logic             phase_hi;
  logic [DIV_W-1:0] cnt;
  logic             run;
  logic [DIV_W-1:0] dly_eff;
  logic [FE_CH-1:0] ch_on;

  pdm_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_enable),
    .div      (cfg_div),
    .phase_hi (phase_hi),
    .cnt      (cnt),
    .run      (run)
  );

  // delay beyond the half period lands on the half's last cycle
  assign dly_eff = (cfg_capt_dly > cfg_div) ? cfg_div : cfg_capt_dly;

  generate
    for (genvar c = 0; c < FE_CH; c++) begin : g_ch
      if (c == 0) begin : g_first
        assign ch_on[c] = run;
      end else begin : g_more
        assign ch_on[c] = run && cfg_two_ch;
      end
      pdm_chan_capture #(.DIV_W(DIV_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (ch_on[c]),
        .bypass   (cfg_bypass),
        .pol_hi   (cfg_pol[c]),
        .dly      (dly_eff),
        .phase_hi (phase_hi),
        .cnt      (cnt),
        .data_i   (pdm_data_i),
        .bit_o    (smp_bit_o[c]),
        .valid_o  (smp_valid_o[c])
      );
    end
  endgenerate

  assign pdm_clk_o = cfg_clk_oe && cfg_enable && (cfg_bypass ? clk : phase_hi);

  // R3
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable || !cfg_clk_oe) |-> !pdm_clk_o);

  // R7
  ch1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_two_ch) |-> !smp_valid_o[1]);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_enable) |-> (smp_valid_o == '0));
endmodule

// File: tb/tb_pdm_frontend.sv
`timescale 1ns/1ps
module tb_pdm_frontend;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0;
  logic [3:0] cfg_div = '0;
  logic       cfg_bypass = 1'b0;
  logic       cfg_clk_oe = 1'b0;
  logic [3:0] cfg_capt_dly = '0;
  logic [1:0] cfg_pol = '0;
  logic       cfg_two_ch = 1'b0;
  logic       pdm_data_i = 1'b0;
  logic       pdm_clk_o;
  logic [1:0] smp_bit_o;
  logic [1:0] smp_valid_o;

  int checks = 0;
  int errors = 0;
  int exp_ch[$];
  logic exp_bit[$];
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #2.5 clk = ~clk;

  pdm_frontend dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_div(cfg_div),
    .cfg_bypass(cfg_bypass), .cfg_clk_oe(cfg_clk_oe), .cfg_capt_dly(cfg_capt_dly),
    .cfg_pol(cfg_pol), .cfg_two_ch(cfg_two_ch), .pdm_data_i(pdm_data_i),
    .pdm_clk_o(pdm_clk_o), .smp_bit_o(smp_bit_o), .smp_valid_o(smp_valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected samples as strobes appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < 2; c++) begin
        if (smp_valid_o[c]) begin
          if (exp_ch.size() == 0) begin
            chk(0, (c == 1) ? "R7/R10 unexpected strobe ch1" : "R10 unexpected strobe ch0", 1, 0);
          end else begin
            int ec;
            logic eb;
            ec = exp_ch.pop_front();
            eb = exp_bit.pop_front();
            chk(ec == c, "R5/R6/R7 strobe channel", c, ec);
            chk(smp_bit_o[c] == eb, "R5 sampled bit", smp_bit_o[c], eb);
          end
        end
      end
    end
  end

  // driver: runs one configuration and pushes the expected samples
  task automatic run_cfg(input int n, input int d, input logic [1:0] pol,
                         input logic two, input logic oe, input logic byp,
                         input int cycles, input bit keep);
    int t;
    int de;
    de = (d > n) ? n : d; // R8 clamp
    if (!keep) begin
      cfg_enable = 1'b0;
      cfg_div = n[3:0]; cfg_capt_dly = d[3:0]; cfg_pol = pol;
      cfg_two_ch = two; cfg_clk_oe = oe; cfg_bypass = byp;
      repeat (3) begin
        @(negedge clk);
        chk(pdm_clk_o == 1'b0, "R3 idle clock low", pdm_clk_o, 0);
      end
      cfg_enable = 1'b1;
    end else begin
      cfg_div = n[3:0]; cfg_capt_dly = d[3:0]; cfg_pol = pol;
      cfg_two_ch = two; cfg_clk_oe = oe; cfg_bypass = byp;
      pdm_data_i = lfsr[0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      chk(pdm_clk_o == 1'b0, "R9 clock low after restart", pdm_clk_o, 0);
    end
    t = 0;
    for (int k = 0; k < cycles; k++) begin
      int ph;
      int cn;
      ph = (t / (n + 1)) % 2;
      cn = t % (n + 1);
      pdm_data_i = lfsr[0];
      for (int c = 0; c < 2; c++) begin
        if (c == 0 || two) begin
          if (byp || (ph == int'(pol[c]) && cn == de)) begin
            exp_ch.push_back(c);
            exp_bit.push_back(lfsr[0]);
          end
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(posedge clk);
      #1;
      if (byp) chk(pdm_clk_o == oe, "R4 bypass clock high phase", pdm_clk_o, oe);
      @(negedge clk);
      t++;
      if (byp) begin
        chk(pdm_clk_o == 1'b0, "R4 bypass clock low phase", pdm_clk_o, 0);
      end else begin
        int e;
        e = oe ? ((t / (n + 1)) % 2) : 0;
        chk(pdm_clk_o == e[0], oe ? "R2 divided clock" : "R3 gated clock", pdm_clk_o, e);
      end
    end
  endtask

  initial begin
    #(5 * 100000);
    chk(0, "watchdog expired", 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(pdm_clk_o == 1'b0, "R1 clock in reset", pdm_clk_o, 0);
    chk(smp_valid_o == 2'b00, "R1 strobes in reset", smp_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_bit_o == 2'b00, "R1 bits after reset", smp_bit_o, 0);
    chk(smp_valid_o == 2'b00, "R1 strobes after reset", smp_valid_o, 0);

    run_cfg(1, 0, 2'b10, 1'b1, 1'b1, 1'b0, 60, 0);   // R6 shared line
    run_cfg(3, 2, 2'b01, 1'b1, 1'b1, 1'b0, 80, 0);   // R6 swapped halves
    run_cfg(2, 9, 2'b00, 1'b0, 1'b1, 1'b0, 60, 0);   // R8 clamp, R7 one channel
    run_cfg(5, 4, 2'b11, 1'b1, 1'b1, 1'b0, 100, 1);  // R9 on-the-fly change
    run_cfg(1, 1, 2'b10, 1'b1, 1'b0, 1'b0, 40, 0);   // R3 output disabled
    run_cfg(1, 0, 2'b00, 1'b1, 1'b1, 1'b1, 30, 0);   // R4 bypass
    run_cfg(0, 0, 2'b10, 1'b1, 1'b1, 1'b0, 40, 0);   // R2 smallest divide

    cfg_enable = 1'b0;
    repeat (12) @(negedge clk);
    // R10
    chk(exp_ch.size() == 0, "R10 all expected samples seen", exp_ch.size(), 0);
    chk(pdm_clk_o == 1'b0, "R3 clock low when disabled", pdm_clk_o, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule